// File: doc/BRIEF.md
# Redundant Clock Failover Selector

This block watches four reference clocks that share one nominal frequency but have no phase relation to each other. It chooses one of them as the active reference for downstream logic. It never clocks anything with those inputs. Each input is sampled in a faster free-running system clock domain and passed through a synchronizer with an edge detector. A per-input watchdog then counts system cycles since the last observed edge and raises a sticky failure flag when the count reaches a timeout.

A three-bit mode input sets the behaviour, and its top bit picks between two modes. In manual mode the low two bits name the reference directly, and failures never move it. In automatic mode the low two bits name a primary input, which becomes the reference on reset or when automatic mode is entered. The block leaves that input only when the input is flagged as failed. It then walks forward in round-robin order (current+1, +2, +3, modulo 4) to the first qualified input. An input is qualified when its external valid pin is high, its enable bit is high and it has no failure flag. If no input qualifies, the selection stays put and an all-failed flag is raised until a candidate appears.

The selection controller has three states. ST_MANUAL tracks the mode field. ST_AUTO_RUN holds the reference while it is healthy, and on a failure it either hops to the next qualified input or drops into ST_AUTO_STRANDED. ST_AUTO_STRANDED returns to ST_AUTO_RUN when the held input qualifies again or when a rotation candidate qualifies. From either automatic state, clearing the top mode bit leads to ST_MANUAL. From ST_MANUAL, setting it leads to ST_AUTO_RUN, with the primary taken from the mode field at that moment.

Top module: `clk_failover_sel`

## Requirements
- R1: While the synchronous active-high reset is high, all failure flags and the all-failed flag are 0, and the selected code equals mode[1:0] at the next clock edge.
- R2: Bit i of the failure flag output rises when input i has shown no transition for more than TIMEOUT system cycles. This holds whether or not input i is selected. An input that toggles at least every few cycles is never flagged.
- R3: Failure flags stay set after the input resumes toggling, until the clear input is pulsed. A clear pulse zeroes every flag and restarts every watchdog count.
- R4: With mode[2] = 0, the selected code equals mode[1:0] one cycle later, and failure flags do not change it.
- R5: With mode[2] = 1, the primary given by mode[1:0] at reset or on entry to automatic mode stays selected while it is not flagged. Later changes to mode[1:0] are ignored while mode[2] stays 1.
- R6: An input qualifies only when its valid pin, its enable bit and the inverse of its failure flag are all 1. Only a qualified input can be switched to.
- R7: When the current automatic reference is flagged, the selection moves to the first qualified input among current+1, current+2 and current+3, taken modulo 4.
- R8: If no input in that rotation qualifies, the selection is held and the all-failed flag is 1. The flag drops, and the selection moves or stays, as soon as a rotation input or the held input qualifies.
- R9: Clearing mode[2] while in automatic mode returns to manual selection of mode[1:0] and clears the all-failed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock, faster than the monitored clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 4 | The four monitored reference clocks, sampled as data |
| ref_ok | input | 4 | External valid indication per input |
| ref_en | input | 4 | Enable bit per input |
| mode | input | 3 | Bit 2: 1 = automatic, 0 = manual; bits 1:0 name the primary or manual input |
| fail_clr | input | 1 | One-cycle pulse that clears all failure flags |
| fail_flag | output | 4 | Sticky failure flag, bit i for input i |
| sel_code | output | 2 | Binary index of the input in use as reference |
| none_ok | output | 1 | High while automatic mode has failed over but found no qualified input |

## Verification
Automatic failover is swept over every primary combined with every valid-pin pattern on the other three inputs. The same sweep then runs over every enable-bit pattern. This separates round-robin order from a fixed priority, and it separates the valid and enable terms of qualification from each other. The pattern where no other input qualifies shows the hold-and-flag behaviour. A second failure on a non-selected candidate before the reference fails shows that a flagged input is skipped, and that a failure elsewhere leaves the reference alone. Manual tracking over all four codes shows that failures are ignored in manual mode. A stalled-then-restarted input shows flag stickiness and the clear pulse.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    localparam int CFS_NUM_IN = 4;
    localparam int CFS_SEL_W  = $clog2(CFS_NUM_IN);

    typedef enum logic [1:0] {
        ST_MANUAL        = 2'd0,
        ST_AUTO_RUN      = 2'd1,
        ST_AUTO_STRANDED = 2'd2
    } cfs_state_e;

    typedef struct packed {
        logic                 found;
        logic [CFS_SEL_W-1:0] idx;
    } cfs_pick_t;

    // First qualified input after cur in rotation order; cur itself is excluded.
    function automatic cfs_pick_t cfs_rr_pick(input logic [CFS_SEL_W-1:0] cur,
                                              input logic [CFS_NUM_IN-1:0] qual);
        cfs_pick_t            res;
        logic [CFS_SEL_W-1:0] cand;
        res.found = 1'b0;
        res.idx   = cur;
        for (int k = CFS_NUM_IN - 1; k >= 1; k--) begin
            cand = cur + CFS_SEL_W'(k);
            if (qual[cand]) begin
                res.found = 1'b1;
                res.idx   = cand;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/cfs_edge_sync.sv
module cfs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    localparam int TOP = SYNC_STAGES;

    logic [TOP:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[TOP-1:0], async_i};
        end
    end

    // Compare the last synchronized stage with one extra history flop.
    assign edge_o = shreg[TOP] ^ shreg[TOP-1];

endmodule

// File: rtl/cfs_watchdog.sv
module cfs_watchdog #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic edge_i,
    output logic fail_o
);
    localparam int            CW  = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i || edge_i) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LIM) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            fail_o <= 1'b0;
        end else if (idle_cnt == LIM) begin
            fail_o <= 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !clr_i) |=> fail_o); // R3
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !fail_o); // R3

endmodule

// File: rtl/cfs_select_fsm.sv
module cfs_select_fsm
    import cfs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            mode_i,
    input  logic [CFS_NUM_IN-1:0] fail_i,
    input  logic [CFS_NUM_IN-1:0] qual_i,
    output logic [CFS_SEL_W-1:0]  sel_o,
    output logic                  none_o
);
    cfs_state_e           st_q, st_d;
    logic [CFS_SEL_W-1:0] cur_q, cur_d;
    cfs_pick_t            pick;
    logic                 auto_req;

    assign auto_req = mode_i[2];
    assign pick     = cfs_rr_pick(cur_q, qual_i);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= auto_req ? ST_AUTO_RUN : ST_MANUAL;
            cur_q <= mode_i[CFS_SEL_W-1:0];
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        unique case (st_q)
            ST_MANUAL: begin
                cur_d = mode_i[CFS_SEL_W-1:0];
                if (auto_req) st_d = ST_AUTO_RUN;
            end
            ST_AUTO_RUN: begin
                if (!auto_req) begin
                    st_d  = ST_MANUAL;
                    cur_d = mode_i[CFS_SEL_W-1:0];
                end else if (fail_i[cur_q]) begin
                    if (pick.found) cur_d = pick.idx;
                    else            st_d  = ST_AUTO_STRANDED;
                end
            end
            ST_AUTO_STRANDED: begin
                if (!auto_req) begin
                    st_d  = ST_MANUAL;
                    cur_d = mode_i[CFS_SEL_W-1:0];
                end else if (qual_i[cur_q]) begin
                    st_d = ST_AUTO_RUN;
                end else if (pick.found) begin
                    st_d  = ST_AUTO_RUN;
                    cur_d = pick.idx;
                end
            end
            default: begin
                st_d  = ST_MANUAL;
                cur_d = mode_i[CFS_SEL_W-1:0];
            end
        endcase
    end

    // Outputs
    always_comb begin
        sel_o  = cur_q;
        none_o = (st_q == ST_AUTO_STRANDED);
    end

    AST_MANUAL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode_i[2])) |-> (sel_o == $past(mode_i[1:0]))); // R4
    AST_HOLD_HEALTHY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AUTO_RUN && mode_i[2] && !fail_i[cur_q]) |=> (sel_o == $past(sel_o))); // R5
    AST_SWITCH_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_MANUAL && mode_i[2]) |=>
        ((sel_o == $past(sel_o)) || ((($past(qual_i) >> sel_o) & 4'b0001) != 4'b0000))); // R6
    AST_STRAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AUTO_STRANDED && mode_i[2] && qual_i == '0) |=>
        (sel_o == $past(sel_o) && none_o)); // R8

endmodule

// File: rtl/clk_failover_sel.sv
module clk_failover_sel
    import cfs_pkg::*;
#(
    parameter int TIMEOUT     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ref_in,
    input  logic [3:0] ref_ok,
    input  logic [3:0] ref_en,
    input  logic [2:0] mode,
    input  logic       fail_clr,
    output logic [3:0] fail_flag,
    output logic [1:0] sel_code,
    output logic       none_ok
);
    logic [CFS_NUM_IN-1:0] edge_seen;
    logic [CFS_NUM_IN-1:0] failed;
    logic [CFS_NUM_IN-1:0] qual;

    for (genvar i = 0; i < CFS_NUM_IN; i++) begin : g_mon
        cfs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .async_i(ref_in[i]),
            .edge_o (edge_seen[i])
        );
        cfs_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
            .clk   (clk),
            .rst   (rst),
            .clr_i (fail_clr),
            .edge_i(edge_seen[i]),
            .fail_o(failed[i])
        );
    end

    assign qual = ref_ok & ref_en & ~failed;

    cfs_select_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .mode_i(mode),
        .fail_i(failed),
        .qual_i(qual),
        .sel_o (sel_code),
        .none_o(none_ok)
    );

    assign fail_flag = failed;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (fail_flag == 4'b0000 && !none_ok)); // R1

endmodule

// File: tb/clk_failover_sel_test.sv
module clk_failover_sel_test;
    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ref_in = 4'b0000;
    logic [3:0] ref_ok = 4'b1111;
    logic [3:0] ref_en = 4'b1111;
    logic [2:0] mode = 3'b000;
    logic       fail_clr = 1'b0;
    logic [3:0] fail_flag;
    logic [1:0] sel_code;
    logic       none_ok;
    logic [3:0] run = 4'b1111;

    int total = 0;
    int bad = 0;

    clk_failover_sel #(.TIMEOUT(TMO), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_ok(ref_ok), .ref_en(ref_en),
        .mode(mode), .fail_clr(fail_clr), .fail_flag(fail_flag),
        .sel_code(sel_code), .none_ok(none_ok)
    );

    always #4 clk = ~clk;

    // Monitored clocks: same rate, different phases, each stoppable.
    initial begin
        int tick = 0;
        forever begin
            @(negedge clk);
            tick++;
            for (int i = 0; i < 4; i++)
                if (run[i] && ((tick + i) % 3 == 0)) ref_in[i] = ~ref_in[i];
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        mode = m; fail_clr = 1'b0; run = 4'b1111; rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(6);
    endtask

    function automatic int exp_pick(input int p, input logic [3:0] q);
        for (int k = 1; k <= 3; k++)
            if (q[(p + k) % 4]) return (p + k) % 4;
        return -1;
    endfunction

    task automatic auto_case(input int p, input logic [3:0] ok, input logic [3:0] en);
        int e;
        ref_ok = ok; ref_en = en;
        do_reset({1'b1, 2'(p)});
        chk("R5 primary held", int'(sel_code), p);
        run[p] = 1'b0;
        cyc(TMO + 12);
        chk("R2 flag on stalled reference", int'(fail_flag), 1 << p);
        e = exp_pick(p, ok & en);
        if (e >= 0) begin
            chk("R7 rotation target", int'(sel_code), e);
            chk("R6 qualified, none_ok low", int'(none_ok), 0);
        end else begin
            chk("R8 selection held", int'(sel_code), p);
            chk("R8 none_ok raised", int'(none_ok), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] msk;
        // R1: state during reset
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m); rst = 1'b1;
            cyc(3);
            chk("R1 sel in reset", int'(sel_code), m % 4);
            chk("R1 flags clear in reset", int'({fail_flag, none_ok}), 0);
        end
        rst = 1'b0;

        // R2: all running, nothing flagged
        do_reset(3'b000);
        cyc(50);
        chk("R2 no false flag", int'(fail_flag), 0);

        // R4: manual tracking over all codes
        for (int c = 0; c < 4; c++) begin
            mode = {1'b0, 2'(c)};
            cyc(2);
            chk("R4 manual select", int'(sel_code), c);
            chk("R4 none_ok low", int'(none_ok), 0);
        end
        // R4 + R2: failures do not move manual selection; unselected input flagged
        mode = 3'b001;
        run = 4'b1001;
        cyc(TMO + 12);
        chk("R2 independent flags", int'(fail_flag), 4'b0110);
        chk("R4 manual ignores failure", int'(sel_code), 1);

        // R3: sticky until clear
        run = 4'b1111;
        cyc(30);
        chk("R3 flags sticky", int'(fail_flag), 4'b0110);
        fail_clr = 1'b1; cyc(1); fail_clr = 1'b0;
        cyc(1);
        chk("R3 clear pulse", int'(fail_flag), 0);
        cyc(30);
        chk("R3 no re-flag when running", int'(fail_flag), 0);

        // R5: low mode bits ignored in automatic mode
        do_reset(3'b101);
        mode = 3'b110;
        cyc(6);
        chk("R5 ignores mode[1:0]", int'(sel_code), 1);

        // R6/R7/R8: valid-pin sweep
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 8; m++) begin
                msk = 4'b0000;
                msk[p] = 1'b1;
                for (int k = 1; k <= 3; k++) msk[(p + k) % 4] = m[k-1];
                auto_case(p, msk, 4'b1111);
            end
        // R6: enable-bit sweep
        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 8; m++) begin
                msk = 4'b0000;
                msk[p] = 1'b1;
                for (int k = 1; k <= 3; k++) msk[(p + k) % 4] = m[k-1];
                auto_case(p, 4'b1111, msk);
            end

        // R7/R6: flagged candidate is skipped; non-reference failure leaves sel
        ref_ok = 4'b1111; ref_en = 4'b1111;
        do_reset(3'b101);
        run[2] = 1'b0;
        cyc(TMO + 12);
        chk("R7 reference kept on other failure", int'(sel_code), 1);
        run[1] = 1'b0;
        cyc(TMO + 12);
        chk("R6 flagged candidate skipped", int'(sel_code), 3);

        // R9: back to manual
        mode = 3'b010;
        cyc(2);
        chk("R9 manual after auto", int'(sel_code), 2);

        // R8: stranded recovery, then R9 clears none_ok
        ref_ok = 4'b0001;
        do_reset(3'b100);
        run[0] = 1'b0;
        cyc(TMO + 12);
        chk("R8 stranded", int'(none_ok), 1);
        ref_ok = 4'b0101;
        cyc(2);
        chk("R8 recovery select", int'(sel_code), 2);
        chk("R8 none_ok drops", int'(none_ok), 0);
        ref_ok = 4'b0001;
        run[2] = 1'b0;
        cyc(TMO + 12);
        chk("R8 stranded again", int'(none_ok), 1);
        mode = 3'b011;
        cyc(2);
        chk("R9 none_ok cleared", int'(none_ok), 0);
        chk("R9 manual code", int'(sel_code), 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule